// File: doc/BRIEF.md
# Folded Hololine Raster Timing Generator

This block produces the pixel-clock timing for one framebuffer channel whose very long holographic scan lines are each folded over many short raster lines. Each short raster line has a fixed tail of samples that the raster hardware always blanks. Hololine blanking is therefore not made by the raster's own blanking. It is made instead by raster lines inside the active region that the pixel source must fill with black. With the default parameters, a raster line has 2048 sample positions and its last 16 are lost to blanking. A hololine takes 178 raster lines: 128 carry fringe data and 50 are black. A frame holds 8 hololines, giving 1424 active lines. 356 padding lines come before them and 8 vertical-sync lines follow them.

The block exports the sample and raster-line counters, the hololine index, the line index within the hololine, a fringe-enable, a forced-black enable, horizontal sync and vertical sync. A downstream pixel source uses these to decide, sample by sample, whether to send fringe data, send black, or send nothing. Every length and count is a parameter, and the parameters are checked when the design is elaborated.

Top module: `hololine_fold_tg`

## Requirements
- R1: `pix_x` starts at 0 after reset, rises by one on every clock and wraps from LINE_LEN-1 to 0.
- R2: `line_y` rises by one each time `pix_x` wraps and returns to 0 after TOP_PAD + HOLOS*LPH + VS_LINES - 1. It does not change on any other clock.
- R3: `fringe_en` is 1 exactly when all three of these hold: `line_y` lies in the active region [TOP_PAD, TOP_PAD+HOLOS*LPH), `holo_line` < FRINGE_LINES, and `pix_x` < LINE_LEN-TAIL_BLANK.
- R4: `black_en` is 1 exactly when `line_y` is in the active region and `fringe_en` is 0. This covers the black hololine-blanking lines and the blanked tail of every active line.
- R5: `hsync` is 1 exactly when `pix_x` lies in [LINE_LEN-TAIL_BLANK+HS_START, LINE_LEN-TAIL_BLANK+HS_START+HS_W), on every raster line including padding and vertical-sync lines.
- R6: `vsync` is 1 exactly when `line_y` >= TOP_PAD+HOLOS*LPH, that is, on the last VS_LINES lines of the frame.
- R7: Inside the active region, `holo_idx` = (line_y-TOP_PAD)/LPH and `holo_line` = (line_y-TOP_PAD) mod LPH. Outside it, both are 0.
- R8: While `rst_n` is low, `pix_x` and `line_y` are 0 and `fringe_en`, `black_en`, `hsync` and `vsync` are 0. Reset is asynchronous and active low.
- R9: On the TOP_PAD padding lines at the start of the frame, `fringe_en`, `black_en` and `vsync` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_x | output | $clog2(LINE_LEN) | Sample position within the raster line |
| line_y | output | $clog2(TOP_PAD+HOLOS*LPH+VS_LINES) | Raster line within the frame |
| holo_idx | output | HOLOS>1 ? $clog2(HOLOS) : 1 | Hololine index in the active region |
| holo_line | output | $clog2(LPH) | Raster line within the current hololine |
| fringe_en | output | 1 | Pixel source must send a fringe sample |
| black_en | output | 1 | Pixel source must send black |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
Two events can fall in the same cycle. Horizontal sync inside the blanked tail of a line can coincide with vertical sync. On the last active line, the wrap of the hololine index to 0 coincides with the region change into vertical sync. The bench runs a shrunken parameter set through several complete frames from a directed reset, and then from resets placed at random points mid-frame. It compares every output on every cycle against a model computed by arithmetic on the cycle count. It also confirms that cycles with both syncs high were actually observed.

// File: rtl/ftg_pkg.sv
package ftg_pkg;

   typedef enum logic [1:0] {
      RGN_TOP    = 2'd0,
      RGN_ACTIVE = 2'd1,
      RGN_VSYNC  = 2'd2
   } region_e;

endpackage

// File: rtl/ftg_hcount.sv
module ftg_hcount #(
   parameter int LINE_LEN   = 2048,
   parameter int TAIL_BLANK = 16,
   parameter int HS_START   = 2,
   parameter int HS_W       = 8,
   localparam int XW        = $clog2(LINE_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [XW-1:0] x,
   output logic          eol,
   output logic          in_body,
   output logic          hsync
);

   localparam logic [XW-1:0] X_LAST = XW'(LINE_LEN - 1);
   localparam logic [XW-1:0] X_BODY = XW'(LINE_LEN - TAIL_BLANK);
   localparam logic [XW:0]   HS_LO  = (XW+1)'(LINE_LEN - TAIL_BLANK + HS_START);
   localparam logic [XW:0]   HS_HI  = (XW+1)'(LINE_LEN - TAIL_BLANK + HS_START + HS_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   x <= '0;
      else if (eol) x <= '0;
      else          x <= x + 1'b1;
   end

   assign eol     = (x == X_LAST);
   assign in_body = (x < X_BODY);

   always_comb begin
      hsync = ({1'b0, x} >= HS_LO) && ({1'b0, x} < HS_HI);
   end

   // R1: counter wraps at the end of the line
   p_x_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (x == X_LAST) |=> (x == '0));
   // R1: counter steps by one elsewhere
   p_x_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (x != X_LAST) |=> (x == $past(x) + 1'b1));
   // R5: sync lies inside the blanked tail
   p_hsync_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hsync |-> !in_body);

endmodule

// File: rtl/ftg_vcount.sv
module ftg_vcount
   import ftg_pkg::*;
#(
   parameter int TOP_PAD  = 356,
   parameter int HOLOS    = 8,
   parameter int LPH      = 178,
   parameter int VS_LINES = 8,
   localparam int TOTAL   = TOP_PAD + HOLOS * LPH + VS_LINES,
   localparam int YW      = $clog2(TOTAL),
   localparam int HLW     = $clog2(LPH),
   localparam int HIW     = (HOLOS > 1) ? $clog2(HOLOS) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           eol,
   output logic [YW-1:0]  y,
   output region_e        region,
   output logic [HIW-1:0] holo_idx,
   output logic [HLW-1:0] holo_line
);

   localparam logic [YW-1:0]  Y_LAST  = YW'(TOTAL - 1);
   localparam logic [YW-1:0]  ACT_LO  = YW'(TOP_PAD);
   localparam logic [YW-1:0]  ACT_HI  = YW'(TOP_PAD + HOLOS * LPH);
   localparam logic [HLW-1:0] HL_LAST = HLW'(LPH - 1);

   logic hl_last;
   logic step_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                y <= '0;
      else if (eol && y == Y_LAST) y <= '0;
      else if (eol)              y <= y + 1'b1;
   end

   always_comb begin
      if (y < ACT_LO)      region = RGN_TOP;
      else if (y < ACT_HI) region = RGN_ACTIVE;
      else                 region = RGN_VSYNC;
   end

   assign hl_last  = (holo_line == HL_LAST);
   assign step_act = eol && (region == RGN_ACTIVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        holo_line <= '0;
      else if (step_act) holo_line <= hl_last ? '0 : holo_line + 1'b1;
   end

   generate
      if (HOLOS > 1) begin : g_multi_holo
         localparam logic [HIW-1:0] HI_LAST = HIW'(HOLOS - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               holo_idx <= '0;
            else if (step_act && hl_last)
               holo_idx <= (holo_idx == HI_LAST) ? '0 : holo_idx + 1'b1;
         end
      end else begin : g_single_holo
         assign holo_idx = '0;
      end
   endgenerate

   // R2: line counter only moves at the end of a raster line
   p_y_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !eol |=> $stable(y));
   // R2: frame wraps after the last line
   p_y_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (eol && y == Y_LAST) |=> (y == '0));
   // R7: indices rest at zero outside the active region
   p_idx_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (region != RGN_ACTIVE) |-> (holo_line == '0 && holo_idx == '0));

endmodule

// File: rtl/ftg_decode.sv
module ftg_decode
   import ftg_pkg::*;
#(
   parameter int LPH          = 178,
   parameter int FRINGE_LINES = 128,
   localparam int HLW         = $clog2(LPH)
) (
   input  region_e        region,
   input  logic           in_body,
   input  logic [HLW-1:0] holo_line,
   output logic           fringe_en,
   output logic           black_en,
   output logic           vsync
);

   localparam logic [HLW-1:0] HL_FR = HLW'(FRINGE_LINES);

   logic active;

   always_comb begin
      active    = (region == RGN_ACTIVE);
      fringe_en = active && in_body && (holo_line < HL_FR);
      black_en  = active && !fringe_en;
      vsync     = (region == RGN_VSYNC);
   end

endmodule

// File: rtl/hololine_fold_tg.sv
module hololine_fold_tg
   import ftg_pkg::*;
#(
   parameter int LINE_LEN     = 2048,
   parameter int TAIL_BLANK   = 16,
   parameter int HS_START     = 2,
   parameter int HS_W         = 8,
   parameter int LPH          = 178,
   parameter int FRINGE_LINES = 128,
   parameter int HOLOS        = 8,
   parameter int TOP_PAD      = 356,
   parameter int VS_LINES     = 8,
   localparam int XW          = $clog2(LINE_LEN),
   localparam int YW          = $clog2(TOP_PAD + HOLOS * LPH + VS_LINES),
   localparam int HLW         = $clog2(LPH),
   localparam int HIW         = (HOLOS > 1) ? $clog2(HOLOS) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   output logic [XW-1:0]  pix_x,
   output logic [YW-1:0]  line_y,
   output logic [HIW-1:0] holo_idx,
   output logic [HLW-1:0] holo_line,
   output logic           fringe_en,
   output logic           black_en,
   output logic           hsync,
   output logic           vsync
);

   localparam logic [XW-1:0] X_BODY = XW'(LINE_LEN - TAIL_BLANK);

   generate
      if (LINE_LEN < 4) begin : g_chk_len
         $error("LINE_LEN must be at least 4");
      end
      if (TAIL_BLANK < 1 || TAIL_BLANK >= LINE_LEN) begin : g_chk_tail
         $error("TAIL_BLANK must lie in [1, LINE_LEN)");
      end
      if (HS_W < 1 || HS_START < 0 || HS_START + HS_W > TAIL_BLANK) begin : g_chk_hs
         $error("sync window must fit inside the blanked tail");
      end
      if (LPH < 2 || FRINGE_LINES < 1 || FRINGE_LINES >= LPH) begin : g_chk_fr
         $error("FRINGE_LINES must lie in [1, LPH)");
      end
      if (TOP_PAD < 1 || VS_LINES < 1 || HOLOS < 1) begin : g_chk_v
         $error("TOP_PAD, VS_LINES and HOLOS must be positive");
      end
   endgenerate

   logic    eol;
   logic    in_body;
   region_e region;

   ftg_hcount #(
      .LINE_LEN  (LINE_LEN),
      .TAIL_BLANK(TAIL_BLANK),
      .HS_START  (HS_START),
      .HS_W      (HS_W)
   ) u_hcount (
      .clk    (clk),
      .rst_n  (rst_n),
      .x      (pix_x),
      .eol    (eol),
      .in_body(in_body),
      .hsync  (hsync)
   );

   ftg_vcount #(
      .TOP_PAD (TOP_PAD),
      .HOLOS   (HOLOS),
      .LPH     (LPH),
      .VS_LINES(VS_LINES)
   ) u_vcount (
      .clk      (clk),
      .rst_n    (rst_n),
      .eol      (eol),
      .y        (line_y),
      .region   (region),
      .holo_idx (holo_idx),
      .holo_line(holo_line)
   );

   ftg_decode #(
      .LPH         (LPH),
      .FRINGE_LINES(FRINGE_LINES)
   ) u_decode (
      .region   (region),
      .in_body  (in_body),
      .holo_line(holo_line),
      .fringe_en(fringe_en),
      .black_en (black_en),
      .vsync    (vsync)
   );

   // R3: no fringe sample in the blanked tail
   p_fringe_body_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fringe_en |-> (pix_x < X_BODY));
   // R4: fringe and black never requested together
   p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(fringe_en && black_en));
   // R6: vertical sync lines carry no pixel request
   p_vsync_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |-> (!fringe_en && !black_en));
   // R9: frame starts in padding with nothing requested
   p_frame_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (line_y == '0) |-> (!fringe_en && !black_en && !vsync));

endmodule

// File: tb/hololine_fold_tg_bench.sv
module hololine_fold_tg_bench;

   localparam int CLK_P = 10;
   localparam int L     = 32;
   localparam int T     = 4;
   localparam int HSS   = 1;
   localparam int HSW   = 2;
   localparam int LPH   = 6;
   localparam int FR    = 4;
   localparam int HO    = 3;
   localparam int TP    = 2;
   localparam int VS    = 2;
   localparam int TOT   = TP + HO * LPH + VS;
   localparam int FRAME = L * TOT;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] pix_x;
   logic [4:0] line_y;
   logic [1:0] holo_idx;
   logic [2:0] holo_line;
   logic       fringe_en, black_en, hsync, vsync;

   int errors = 0;
   int checks = 0;
   int both_seen = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   hololine_fold_tg #(
      .LINE_LEN(L), .TAIL_BLANK(T), .HS_START(HSS), .HS_W(HSW),
      .LPH(LPH), .FRINGE_LINES(FR), .HOLOS(HO), .TOP_PAD(TP), .VS_LINES(VS)
   ) u_hololine_fold_tg (
      .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .line_y(line_y),
      .holo_idx(holo_idx), .holo_line(holo_line), .fringe_en(fringe_en),
      .black_en(black_en), .hsync(hsync), .vsync(vsync)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at time %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_x(int n);
      return n % L;
   endfunction

   function automatic int exp_y(int n);
      return (n / L) % TOT;
   endfunction

   function automatic bit exp_act(int y);
      return (y >= TP) && (y < TP + HO * LPH);
   endfunction

   task automatic check_all(input int n);
      int x, y, hl, hi;
      bit act, fe, be, hs, vs;
      x   = exp_x(n);
      y   = exp_y(n);
      act = exp_act(y);
      hl  = act ? (y - TP) % LPH : 0;
      hi  = act ? (y - TP) / LPH : 0;
      fe  = act && (hl < FR) && (x < L - T);
      be  = act && !fe;
      hs  = (x >= L - T + HSS) && (x < L - T + HSS + HSW);
      vs  = (y >= TP + HO * LPH);
      chk("R1 pix_x", int'(pix_x), x);
      chk("R2 line_y", int'(line_y), y);
      chk("R3 fringe_en", int'(fringe_en), int'(fe));
      chk("R4 black_en", int'(black_en), int'(be));
      chk("R5 hsync", int'(hsync), int'(hs));
      chk("R6 vsync", int'(vsync), int'(vs));
      chk("R7 holo_idx", int'(holo_idx), hi);
      chk("R7 holo_line", int'(holo_line), hl);
      if (y < TP)
         chk("R9 padding quiet", int'({fringe_en, black_en, vsync}), 0);
      if (hsync && vsync) both_seen++;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8 reset pix_x", int'(pix_x), 0);
      chk("R8 reset line_y", int'(line_y), 0);
      chk("R8 reset enables/syncs", int'({fringe_en, black_en, hsync, vsync}), 0);
   endtask

   task automatic run_segment(input int len);
      int n;
      rst_n = 1'b1;
      n = 0;
      check_all(n);
      repeat (len) begin
         @(negedge clk);
         n++;
         check_all(n);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk("R8 reset pix_x", int'(pix_x), 0);
      chk("R8 reset line_y", int'(line_y), 0);
      chk("R8 reset enables/syncs", int'({fringe_en, black_en, hsync, vsync}), 0);
      // directed: two full frames plus a margin to cross both wraps
      run_segment(2 * FRAME + 7);
      // random: resets landing at arbitrary points of the frame
      for (int s = 0; s < 5; s++) begin
         int len;
         len = $urandom_range(2 * FRAME, FRAME / 4);
         do_reset();
         run_segment(len);
      end
      // R5/R6: both syncs must have been seen together on vertical sync lines
      chk("R5 R6 coincident syncs seen", int'(both_seen > 0), 1);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule